// File: doc/BRIEF.md
# PWM Sample Timer and Interrupt Divider

This block sets the sample rate of a two-channel PWM audio unit and tells the host when to refill the channel queues. A 12-bit cycle register holds the sample period, stored as the written value minus one, modulo 4096. A period counter advances on each clock where the enable input is high. When it completes a period it emits a one-cycle sample tick, which the surrounding FIFOs use to pop one entry per channel. An interrupt divider counts these ticks. After a programmable number of them, from 1 to 16, it raises an interrupt that stays up until the host clears it. If enabled, each interrupt event also produces a one-cycle DMA request pulse.

Three small state machines make up the block. The period timer is in TMR_OFF while the stored period is zero and in TMR_RUN otherwise. Its transitions are OFF to RUN on a write of a nonzero period and RUN to OFF on a write of a zero period. A cycle write in either state restarts the phase from zero. The divider starts in DIV_EMPTY after reset and moves to DIV_COUNT on the first control write, or on the first cycle write if that comes earlier. Once in DIV_COUNT it counts down on ticks and reloads itself on every interrupt. The interrupt machine moves from IRQ_IDLE to IRQ_PEND when the divider fires, and back to IRQ_IDLE when it is cleared.

Top module: `pwm_tick_core`

## Requirements
- R1: After reset, tick_o, irq_o and dreq_o are low, period_o is 0, and no tick appears until a cycle write.
- R2: One cycle after a cycle write, period_o equals (cyc_data[11:0] − 1) mod 4096. Bits 15:12 of the write are ignored.
- R3: In TMR_RUN with period P, tick_o pulses once every P clocks on which ce is high. Clocks with ce low are not counted. The first tick is visible in the cycle after the P-th enabled edge that follows the write edge.
- R4: A stored period of 0 (written value 1, or any value whose low 12 bits are 1) puts the timer in TMR_OFF. In TMR_OFF, no tick and no interrupt occur.
- R5: The tick count R comes from ctl_data[11:8], and a field value of 0 selects 16. irq_o rises one cycle after the R-th tick since the last reload, and the divider then reloads with R.
- R6: In IRQ_PEND, irq_o stays high until a cycle with irq_clr high. It is low on the following cycle unless a new interrupt fires.
- R7: When control bit 7 is 1, each interrupt event drives dreq_o high for one cycle, rising together with irq_o. When bit 7 is 0, dreq_o stays low.
- R8: A control write reloads the divider with the new R on the same edge and discards any partial count.
- R9: A cycle write reloads the divider only in DIV_EMPTY. In DIV_COUNT, the remaining count is kept.
- R10: A cycle write restarts the period phase from zero, so the next tick is a full period after the write.
- R11: If an interrupt fires on the same edge as irq_clr, the interrupt stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable for the period counter |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 16 | Control value: bits 11:8 tick count, bit 7 DMA request enable |
| cyc_wr | input | 1 | Cycle register write strobe |
| cyc_data | input | 16 | Cycle value; the low 12 bits are used |
| irq_clr | input | 1 | One-cycle interrupt acknowledge |
| tick_o | output | 1 | Sample tick, one cycle per period |
| irq_o | output | 1 | Interrupt request, held until cleared |
| dreq_o | output | 1 | DMA request pulse |
| period_o | output | 12 | Stored effective period |

## Verification
Every result has a fixed latency. period_o follows a write by one cycle. With ce held high, the first tick appears P+1 cycles after the write is presented. irq_o and dreq_o appear one cycle after the tick that empties the count, and a clear takes effect one cycle after its strobe. The bench drives inputs and samples outputs only on falling edges, and numbers each falling edge after a stimulus. It compares the number at which each event is first seen, and the number of events inside a window, against values it works out from P, R and the ce pattern. A sweep over all sixteen count fields and three short periods covers the main divider arithmetic.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

    typedef enum logic {
        TMR_OFF = 1'b0,
        TMR_RUN = 1'b1
    } tmr_state_e;

    typedef enum logic {
        DIV_EMPTY = 1'b0,
        DIV_COUNT = 1'b1
    } div_state_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

endpackage

// File: rtl/pwm_tick_regs.sv
module pwm_tick_regs #(
    parameter int REG_W    = 16,
    parameter int PER_W    = 12,
    parameter int FLD_W    = 4,
    parameter int FLD_LSB  = 8,
    parameter int DREQ_BIT = 7,
    parameter int RLD_W    = FLD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_data,
    input  logic             cyc_wr,
    input  logic [REG_W-1:0] cyc_data,
    output logic [PER_W-1:0] period_q,
    output logic [PER_W-1:0] period_nxt,
    output logic [RLD_W-1:0] rld_nxt,
    output logic             dreq_en
);

    localparam logic [RLD_W-1:0] RLD_MAX = RLD_W'(2 ** FLD_W);

    logic [FLD_W-1:0] fld_q;
    logic [FLD_W-1:0] fld_nxt;
    logic             en_q;
    logic             en_nxt;
    logic             unused_bits;

    // Bits outside the decoded fields have no function.
    assign unused_bits = ^{ctl_data, cyc_data};

    // Next-state values are exposed so that a write acts on the same edge.
    always_comb begin
        fld_nxt    = ctl_wr ? ctl_data[FLD_LSB +: FLD_W] : fld_q;
        en_nxt     = ctl_wr ? ctl_data[DREQ_BIT] : en_q;
        period_nxt = cyc_wr ? (cyc_data[PER_W-1:0] - PER_W'(1)) : period_q;
    end

    // A field of zero wraps around to the largest count.
    always_comb begin
        if (fld_nxt == '0) begin
            rld_nxt = RLD_MAX;
        end else begin
            rld_nxt = RLD_W'(fld_nxt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            fld_q    <= '0;
            en_q     <= 1'b0;
        end else begin
            period_q <= period_nxt;
            fld_q    <= fld_nxt;
            en_q     <= en_nxt;
        end
    end

    assign dreq_en = en_q;

endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
    import pwm_tick_pkg::*;
#(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             restart,
    input  logic [PER_W-1:0] period_q,
    input  logic [PER_W-1:0] period_nxt,
    output logic             tick_o
);

    tmr_state_e       st_q;
    tmr_state_e       st_n;
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] cnt_n;
    logic [PER_W-1:0] last;
    logic             tick_n;
    logic             tick_q;

    assign last = period_q - PER_W'(1);

    // Next state and phase.
    always_comb begin
        st_n   = (period_nxt == '0) ? TMR_OFF : TMR_RUN;
        cnt_n  = cnt_q;
        tick_n = 1'b0;
        unique case (st_q)
            TMR_OFF: begin
                cnt_n = '0;
            end
            TMR_RUN: begin
                if (ce) begin
                    if (cnt_q == last) begin
                        cnt_n  = '0;
                        tick_n = 1'b1;
                    end else begin
                        cnt_n = cnt_q + PER_W'(1);
                    end
                end
            end
        endcase
        if (restart) begin
            cnt_n  = '0;
            tick_n = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TMR_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_n;
        end
    end

    assign tick_o = tick_q;

    AST_TICK_NEEDS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) tick_q |-> ($past(period_q) != '0)); // R4
    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (st_q == TMR_RUN) |-> (cnt_q < period_q)); // R3

endmodule

// File: rtl/pwm_irq_divider.sv
module pwm_irq_divider
    import pwm_tick_pkg::*;
#(
    parameter int FLD_W = 4,
    parameter int RLD_W = FLD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctl_wr,
    input  logic             cyc_wr,
    input  logic [RLD_W-1:0] rld,
    input  logic             dreq_en,
    input  logic             irq_clr,
    output logic             irq_o,
    output logic             dreq_o
);

    localparam logic [RLD_W-1:0] RLD_MAX = RLD_W'(2 ** FLD_W);

    div_state_e       dst_q;
    div_state_e       dst_n;
    irq_state_e       ist_q;
    irq_state_e       ist_n;
    logic [RLD_W-1:0] cnt_q;
    logic [RLD_W-1:0] cnt_n;
    logic             fire;
    logic             dreq_q;

    // Divider next state. A control write always reloads.
    always_comb begin
        dst_n = dst_q;
        cnt_n = cnt_q;
        fire  = 1'b0;
        if (ctl_wr) begin
            dst_n = DIV_COUNT;
            cnt_n = rld;
        end else begin
            unique case (dst_q)
                DIV_EMPTY: begin
                    if (cyc_wr) begin
                        dst_n = DIV_COUNT;
                        cnt_n = rld;
                    end
                end
                DIV_COUNT: begin
                    if (tick) begin
                        if (cnt_q <= RLD_W'(1)) begin
                            fire  = 1'b1;
                            cnt_n = rld;
                        end else begin
                            cnt_n = cnt_q - RLD_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // Interrupt next state. A new event wins over a clear.
    always_comb begin
        ist_n = ist_q;
        unique case (ist_q)
            IRQ_IDLE: begin
                if (fire) begin
                    ist_n = IRQ_PEND;
                end
            end
            IRQ_PEND: begin
                if (irq_clr && !fire) begin
                    ist_n = IRQ_IDLE;
                end
            end
        endcase
    end

    // State registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_q <= DIV_EMPTY;
            cnt_q <= '0;
            ist_q <= IRQ_IDLE;
        end else begin
            dst_q <= dst_n;
            cnt_q <= cnt_n;
            ist_q <= ist_n;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dreq_q <= 1'b0;
        end else begin
            dreq_q <= fire && dreq_en;
        end
    end

    assign irq_o  = (ist_q == IRQ_PEND);
    assign dreq_o = dreq_q;

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) (dst_q == DIV_COUNT) |-> ((cnt_q != '0) && (cnt_q <= RLD_MAX))); // R5
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) ($past(irq_o) && !$past(irq_clr)) |-> irq_o); // R6
    AST_DREQ_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n) dreq_o |-> irq_o); // R7
    AST_DREQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) dreq_o |-> $past(dreq_en)); // R7
    AST_FIRE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $past(fire) |-> irq_o); // R11

endmodule

// File: rtl/pwm_tick_core.sv
module pwm_tick_core #(
    parameter int REG_W    = 16,
    parameter int PER_W    = 12,
    parameter int FLD_W    = 4,
    parameter int FLD_LSB  = 8,
    parameter int DREQ_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_data,
    input  logic             cyc_wr,
    input  logic [REG_W-1:0] cyc_data,
    input  logic             irq_clr,
    output logic             tick_o,
    output logic             irq_o,
    output logic             dreq_o,
    output logic [PER_W-1:0] period_o
);

    localparam int RLD_W = FLD_W + 1;

    logic [PER_W-1:0] period_q;
    logic [PER_W-1:0] period_nxt;
    logic [RLD_W-1:0] rld_nxt;
    logic             dreq_en;
    logic             tick;

    pwm_tick_regs #(
        .REG_W   (REG_W),
        .PER_W   (PER_W),
        .FLD_W   (FLD_W),
        .FLD_LSB (FLD_LSB),
        .DREQ_BIT(DREQ_BIT),
        .RLD_W   (RLD_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_data  (ctl_data),
        .cyc_wr    (cyc_wr),
        .cyc_data  (cyc_data),
        .period_q  (period_q),
        .period_nxt(period_nxt),
        .rld_nxt   (rld_nxt),
        .dreq_en   (dreq_en)
    );

    pwm_period_timer #(
        .PER_W(PER_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .restart   (cyc_wr),
        .period_q  (period_q),
        .period_nxt(period_nxt),
        .tick_o    (tick)
    );

    pwm_irq_divider #(
        .FLD_W(FLD_W),
        .RLD_W(RLD_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .ctl_wr (ctl_wr),
        .cyc_wr (cyc_wr),
        .rld    (rld_nxt),
        .dreq_en(dreq_en),
        .irq_clr(irq_clr),
        .irq_o  (irq_o),
        .dreq_o (dreq_o)
    );

    assign tick_o   = tick;
    assign period_o = period_q;

endmodule

// File: tb/tb_pwm_tick_core.sv
module tb_pwm_tick_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_data = '0;
    logic        cyc_wr = 1'b0;
    logic [15:0] cyc_data = '0;
    logic        irq_clr = 1'b0;
    logic        tick_o;
    logic        irq_o;
    logic        dreq_o;
    logic [11:0] period_o;

    int checks = 0;
    int errors = 0;
    int first_tick, ntick, first_irq, first_dreq, ndreq, per_k1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_tick_core dut (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .cyc_wr(cyc_wr), .cyc_data(cyc_data),
        .irq_clr(irq_clr),
        .tick_o(tick_o), .irq_o(irq_o), .dreq_o(dreq_o), .period_o(period_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present a cycle write, then observe W falling edges (k = 1..W).
    task automatic run_cyc(input logic [15:0] v, input int w, input int lim, input bit alt);
        cyc_wr = 1'b1;
        cyc_data = v;
        ce = alt ? 1'b0 : 1'b1;
        first_tick = 0; ntick = 0; first_irq = 0; first_dreq = 0; ndreq = 0; per_k1 = -1;
        for (int k = 1; k <= w; k++) begin
            @(negedge clk);
            if (k == 1) begin
                per_k1 = int'(period_o);
                cyc_wr = 1'b0;
            end
            if (tick_o) begin
                if (first_tick == 0) first_tick = k;
                if (k <= lim) ntick++;
            end
            if (irq_o && first_irq == 0) first_irq = k;
            if (dreq_o) begin
                if (first_dreq == 0) first_dreq = k;
                if (k <= lim) ndreq++;
            end
            if (alt) ce = (k % 2 == 0);
        end
        ce = 1'b1;
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_wr = 1'b1;
        ctl_data = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic clr_pulse();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic setup_idle();
        run_cyc(16'h0001, 3, 0, 1'b0);
        clr_pulse();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!tick_o && !irq_o && !dreq_o, "R1 outputs low", {tick_o, irq_o, dreq_o}, 0);
        chk(period_o == 12'd0, "R1 period", int'(period_o), 0);
        ntick = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (tick_o) ntick++;
        end
        chk(ntick == 0, "R1 no tick before write", ntick, 0);

        // R9 first cycle write reloads from empty; field 0 -> 16 ticks
        run_cyc(16'h0002, 20, 20, 1'b0);
        chk(first_tick == 2, "R3 first tick P=1", first_tick, 2);
        chk(first_irq == 18, "R9 reload from empty (R=16)", first_irq, 18);
        chk(first_dreq == 0, "R7 dreq off by default", first_dreq, 0);
        setup_idle();

        // R2 stored period
        run_cyc(16'h1005, 1, 1, 1'b0);
        chk(per_k1 == 4, "R2 upper bits ignored", per_k1, 4);
        run_cyc(16'h0000, 1, 1, 1'b0);
        chk(per_k1 == 4095, "R2 wrap of zero", per_k1, 4095);
        setup_idle();
        chk(period_o == 12'd0, "R2 value one gives zero", int'(period_o), 0);

        // R4 zero period: no ticks, no interrupt
        wr_ctl(16'h0100);
        run_cyc(16'h1001, 40, 40, 1'b0);
        chk(per_k1 == 0, "R4 period zero", per_k1, 0);
        chk(first_tick == 0, "R4 no tick", first_tick, 0);
        chk(first_irq == 0, "R4 no irq", first_irq, 0);

        // R3 clock enable gating, P=3, ce on alternate edges
        setup_idle();
        wr_ctl(16'h0F00);
        run_cyc(16'h0004, 60, 60, 1'b1);
        chk(first_tick == 7, "R3 first tick with gated ce", first_tick, 7);
        chk(ntick == 9, "R3 tick count with gated ce", ntick, 9);

        // R9 kept count and R10 restart
        setup_idle();
        wr_ctl(16'h0300);
        run_cyc(16'h0003, 5, 5, 1'b0);
        chk(ntick == 2, "R3 two ticks P=2", ntick, 2);
        run_cyc(16'h0001, 3, 3, 1'b0);
        chk(first_irq == 0, "R5 no early irq", first_irq, 0);
        run_cyc(16'h0003, 10, 10, 1'b0);
        chk(first_tick == 3, "R10 phase restarts", first_tick, 3);
        chk(first_irq == 4, "R9 count kept in COUNT state", first_irq, 4);

        // R8 control write discards partial count
        setup_idle();
        wr_ctl(16'h0300);
        run_cyc(16'h0003, 5, 5, 1'b0);
        run_cyc(16'h0001, 3, 3, 1'b0);
        wr_ctl(16'h0300);
        run_cyc(16'h0003, 12, 12, 1'b0);
        chk(first_irq == 8, "R8 control write reloads", first_irq, 8);

        // R6 hold until clear
        setup_idle();
        wr_ctl(16'h0100);
        run_cyc(16'h0003, 4, 4, 1'b0);
        chk(first_irq == 4, "R5 R=1 P=2", first_irq, 4);
        run_cyc(16'h0001, 10, 10, 1'b0);
        chk(irq_o == 1'b1, "R6 irq held", int'(irq_o), 1);
        clr_pulse();
        chk(irq_o == 1'b0, "R6 irq cleared", int'(irq_o), 0);

        // R11 new event beats clear
        setup_idle();
        wr_ctl(16'h0180);
        run_cyc(16'h0003, 4, 4, 1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (tick_o) begin
                irq_clr = 1'b1;
                @(negedge clk);
                irq_clr = 1'b0;
                chk(irq_o == 1'b1, "R11 fire beats clear", int'(irq_o), 1);
                chk(dreq_o == 1'b1, "R7 dreq on repeat event", int'(dreq_o), 1);
                break;
            end
        end

        // Sweep: all count fields, periods 1..3 (R5, R7, R3)
        for (int p = 1; p <= 3; p++) begin
            for (int f = 0; f < 16; f++) begin
                int r;
                int lim;
                int exp_ticks;
                bit en;
                r = (f == 0) ? 16 : f;
                en = ((f + p) % 2) == 1;
                lim = r * p + 2;
                exp_ticks = (lim - p - 1) / p + 1;
                setup_idle();
                wr_ctl({4'h0, 4'(f), en, 7'h00});
                run_cyc(16'(p + 1), r * p + 4, lim, 1'b0);
                chk(first_tick == p + 1, "R3 sweep first tick", first_tick, p + 1);
                chk(ntick == exp_ticks, "R3 sweep tick count", ntick, exp_ticks);
                chk(first_irq == r * p + 2, "R5 sweep irq cycle", first_irq, r * p + 2);
                if (en) begin
                    chk(first_dreq == r * p + 2, "R7 sweep dreq cycle", first_dreq, r * p + 2);
                    chk(ndreq == 1, "R7 sweep dreq single", ndreq, 1);
                end else begin
                    chk(ndreq == 0, "R7 sweep dreq disabled", ndreq, 0);
                end
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule